// File: doc/BRIEF.md
# Permuting DRAM Address Multiplexer and Access Sequencer

This block sits between two requesters and a pair of 64K-deep DRAM banks that share one multiplexed address bus. One requester is a processor that reads and writes single bytes. The other is a display fetch engine that reads word pairs. The block picks one request at a time, with the display engine winning any contest. It splits the 16-bit byte address into an 8-bit row half and an 8-bit column half, then runs one row-strobe / column-strobe access cycle.

The split is not a plain high/low cut. The low address bits go onto the row lines, so a display engine walking linearly through memory touches every DRAM row within a short window. That walk is what keeps the array refreshed. Two bit orders can be selected. Mode 1 keeps both halves in ascending order. Mode 0 uses the same halves but swaps each adjacent pair of lines. The row strobe and address lines are common to both banks, and only the column strobe is chosen per bank. Every access therefore refreshes the addressed row in both banks. Processor refresh-phase cycles are dropped without touching the DRAM.

Top module: `dram_addr_seq`

## Requirements
- R1: With `perm_mode`=1, the row half is A8..A1 on row lines 7..0, and the column half is A15..A9 on column lines 7..1 with A0 on column line 0.
- R2: With `perm_mode`=0, each half is formed as in R1 and then every adjacent pair of lines is exchanged (line 2k with 2k+1). For example, A1 drives row line 1, A2 drives row line 0, and A0 drives column line 1.
- R3: A display fetch uses the byte address {`vid_waddr`, `vid_phase`}, so the phase bit selects word 2n or 2n+1. It always strobes the bank 0 column strobe (`dram_cas_n`=2'b10).
- R4: An uncontended access granted at a clock edge works as follows. For one cycle the row half is on the bus with all strobes high. For the next cycle the row strobe is low and the row half is held. For the third cycle the column half is on the bus with the column strobe low.
- R5: A processor access strobes only `dram_cas_n[cpu_bank]`. The shared row strobe is low in both the row and column phases whichever bank is chosen.
- R6: A processor request with `cpu_refresh`=1 starts no DRAM cycle, and `cpu_ready` stays high for it.
- R7: When both ports request together, the display port is served first. `cpu_ready` stays low from the cycle of a live processor request until the cycle its own access completes.
- R8: All strobes return high in the same cycle. The row strobe then stays high for at least one cycle before it can fall again.
- R9: Read data is captured at the edge that ends the column phase. It is presented with a one-cycle `cpu_rvalid` or `vid_rvalid` pulse in the following cycle. A write drives `dram_we_n` low during the column phase with `cpu_wdata` on `dram_wdata`, and gives no `cpu_rvalid`.
- R10: During reset all strobes and `dram_we_n` are high and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_mode | input | 1 | Address bit order: 0 pair-swapped, 1 ascending |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_refresh | input | 1 | Marks the request as a refresh-phase cycle to drop |
| cpu_we | input | 1 | Processor write when 1 |
| cpu_bank | input | 1 | Processor bank select |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_ready | output | 1 | Low while a live processor request waits |
| cpu_rvalid | output | 1 | Processor read data valid pulse |
| cpu_rdata | output | 8 | Processor read data |
| vid_req | input | 1 | Display fetch request, held until `vid_rvalid` |
| vid_waddr | input | 15 | Display word address (byte address bits 15..1) |
| vid_phase | input | 1 | Character clock phase, becomes address bit 0 |
| vid_rvalid | output | 1 | Display read data valid pulse |
| vid_rdata | output | 8 | Display read data |
| dram_addr | output | 8 | Multiplexed row / column address |
| dram_ras_n | output | 1 | Shared row strobe, active low |
| dram_cas_n | output | 2 | Per-bank column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | 8 | Data to DRAM |
| dram_rdata | input | 8 | Data from DRAM |

## Verification
The bench walks both bit orders with asymmetric addresses such as 0x1234, 0xC001 and 0xAAAA. A row/column swap, a missed pair exchange or a misplaced A0 would put a wrong value on the bus during the row or column phase, and a later read would also return a value written elsewhere. It runs the two requests at the same moment to catch an arbiter that lets the processor in first or raises `cpu_ready` early. It also sends a refresh-phase request, which a faulty design would turn into a row strobe or a stalled processor. Display fetches of both phase values and bank-1 writes catch a dropped phase bit, a wrong column strobe, or a row strobe that is not shared.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_RAS  = 3'd2,
    ST_CAS  = 3'd3,
    ST_PRE  = 3'd4
  } seq_state_e;

  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_VID = 1'b1
  } src_e;
endpackage

// File: rtl/dram_arbiter.sv
`timescale 1ns/1ps
module dram_arbiter (
  input  logic accept,
  input  logic vid_req,
  input  logic cpu_req,
  input  logic cpu_refresh,
  output logic grant_vid,
  output logic grant_cpu
);
  logic cpu_live;

  // refresh-phase cycles never compete for the bus
  assign cpu_live  = cpu_req && !cpu_refresh;
  assign grant_vid = accept && vid_req;
  assign grant_cpu = accept && cpu_live && !vid_req;
endmodule

// File: rtl/dram_addr_perm.sv
`timescale 1ns/1ps
module dram_addr_perm #(
  parameter int HALF_W = 8,
  localparam int ADDR_W = 2 * HALF_W
) (
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  output logic [HALF_W-1:0] row,
  output logic [HALF_W-1:0] col
);
  // ascending row half: address bits just above bit 0
  function automatic logic [HALF_W-1:0] asc_row(input logic [ADDR_W-1:0] a);
    return a[HALF_W:1];
  endfunction

  // ascending column half: top bits, with bit 0 as the lowest line
  function automatic logic [HALF_W-1:0] asc_col(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:HALF_W+1], a[0]};
  endfunction

  // exchange lines 2k and 2k+1
  function automatic logic [HALF_W-1:0] swap_pairs(input logic [HALF_W-1:0] v);
    logic [HALF_W-1:0] r;
    for (int j = 0; j < HALF_W; j++) r[j] = v[j ^ 1];
    return r;
  endfunction

  logic [HALF_W-1:0] row_asc, col_asc;
  assign row_asc = asc_row(addr);
  assign col_asc = asc_col(addr);
  assign row = mode ? row_asc : swap_pairs(row_asc);
  assign col = mode ? col_asc : swap_pairs(col_asc);
endmodule

// File: rtl/dram_strobe_fsm.sv
`timescale 1ns/1ps
module dram_strobe_fsm
  import dram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic ras_phase,
  output logic cas_phase,
  output logic pre_phase
);
  seq_state_e state, state_nxt;

  always_comb begin
    case (state)
      ST_IDLE: state_nxt = start ? ST_ROW : ST_IDLE;
      ST_ROW:  state_nxt = ST_RAS;
      ST_RAS:  state_nxt = ST_CAS;
      ST_CAS:  state_nxt = ST_PRE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  assign idle      = (state == ST_IDLE);
  assign ras_phase = (state == ST_RAS);
  assign cas_phase = (state == ST_CAS);
  assign pre_phase = (state == ST_PRE);
endmodule

// File: rtl/dram_addr_seq.sv
`timescale 1ns/1ps
module dram_addr_seq
  import dram_seq_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DATA_W = 8,
  parameter int BANKS  = 2,
  localparam int ADDR_W = 2 * HALF_W,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              perm_mode,
  input  logic              cpu_req,
  input  logic              cpu_refresh,
  input  logic              cpu_we,
  input  logic [BANK_W-1:0] cpu_bank,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              vid_req,
  input  logic [ADDR_W-2:0] vid_waddr,
  input  logic              vid_phase,
  output logic              vid_rvalid,
  output logic [DATA_W-1:0] vid_rdata,
  output logic [HALF_W-1:0] dram_addr,
  output logic              dram_ras_n,
  output logic [BANKS-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata
);
  // named internal events, also used by the bound checker
  logic grant_vid, grant_cpu, seq_idle, ras_phase, cas_phase, pre_phase;
  logic cpu_done;

  logic [ADDR_W-1:0] lat_addr;
  logic              lat_mode, lat_we;
  src_e              lat_src;
  logic [BANK_W-1:0] lat_bank;
  logic [DATA_W-1:0] lat_wdata, rdata_q;
  logic [HALF_W-1:0] row_half, col_half;

  dram_arbiter arb_i (
    .accept     (seq_idle),
    .vid_req    (vid_req),
    .cpu_req    (cpu_req),
    .cpu_refresh(cpu_refresh),
    .grant_vid  (grant_vid),
    .grant_cpu  (grant_cpu)
  );

  dram_strobe_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (grant_vid || grant_cpu),
    .idle     (seq_idle),
    .ras_phase(ras_phase),
    .cas_phase(cas_phase),
    .pre_phase(pre_phase)
  );

  dram_addr_perm #(.HALF_W(HALF_W)) perm_i (
    .mode(lat_mode),
    .addr(lat_addr),
    .row (row_half),
    .col (col_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_mode  <= 1'b0;
      lat_we    <= 1'b0;
      lat_src   <= SRC_CPU;
      lat_bank  <= '0;
      lat_wdata <= '0;
    end else if (grant_vid) begin
      lat_addr  <= {vid_waddr, vid_phase};
      lat_mode  <= perm_mode;
      lat_we    <= 1'b0;
      lat_src   <= SRC_VID;
      lat_bank  <= '0;
    end else if (grant_cpu) begin
      lat_addr  <= cpu_addr;
      lat_mode  <= perm_mode;
      lat_we    <= cpu_we;
      lat_src   <= SRC_CPU;
      lat_bank  <= cpu_bank;
      lat_wdata <= cpu_wdata;
    end
  end

  // capture at the edge that closes the column phase
  always_ff @(posedge clk) begin
    if (!rst_n)                  rdata_q <= '0;
    else if (cas_phase && !lat_we) rdata_q <= dram_rdata;
  end

  assign dram_addr  = cas_phase ? col_half : row_half;
  assign dram_ras_n = !(ras_phase || cas_phase);
  assign dram_we_n  = !(cas_phase && lat_we);
  assign dram_wdata = lat_wdata;

  for (genvar b = 0; b < BANKS; b++) begin : g_cas
    assign dram_cas_n[b] = !(cas_phase && (lat_bank == BANK_W'(b)));
  end

  assign cpu_done   = pre_phase && (lat_src == SRC_CPU);
  assign cpu_rvalid = cpu_done && !lat_we;
  assign vid_rvalid = pre_phase && (lat_src == SRC_VID);
  assign cpu_ready  = !cpu_req || cpu_refresh || cpu_done;
  assign cpu_rdata  = rdata_q;
  assign vid_rdata  = rdata_q;
endmodule

// File: rtl/dram_addr_seq_chk.sv
`timescale 1ns/1ps
module dram_addr_seq_chk #(
  parameter int HALF_W = 8,
  parameter int BANKS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] dram_addr,
  input logic              dram_ras_n,
  input logic [BANKS-1:0]  dram_cas_n,
  input logic              grant_vid,
  input logic              grant_cpu,
  input logic              vid_req,
  input logic              cpu_req,
  input logic              cpu_refresh,
  input logic              cpu_ready,
  input logic              cpu_rvalid,
  input logic              vid_rvalid
);
  localparam logic [BANKS-1:0] CAS_OFF = '1;

  p_row_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  p_cas_after_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cas_n != CAS_OFF) |-> (!dram_ras_n && !$past(dram_ras_n)));

  p_one_cas_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dram_cas_n));

  p_refresh_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_refresh) |-> (cpu_ready && !grant_cpu));

  p_vid_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_cpu |-> (!vid_req && !grant_vid));

  p_rise_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ((dram_cas_n == CAS_OFF) && ($past(dram_cas_n) != CAS_OFF)));

  p_precharge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);

  p_cpu_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |=> !cpu_rvalid);

  p_vid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vid_rvalid |=> !vid_rvalid);
endmodule

bind dram_addr_seq dram_addr_seq_chk #(.HALF_W(HALF_W), .BANKS(BANKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .dram_addr  (dram_addr),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .grant_vid  (grant_vid),
  .grant_cpu  (grant_cpu),
  .vid_req    (vid_req),
  .cpu_req    (cpu_req),
  .cpu_refresh(cpu_refresh),
  .cpu_ready  (cpu_ready),
  .cpu_rvalid (cpu_rvalid),
  .vid_rvalid (vid_rvalid)
);

// File: tb/dram_addr_seq_tb_top.sv
`timescale 1ns/1ps
module dram_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        perm_mode = 1'b0;
  logic        cpu_req = 1'b0, cpu_refresh = 1'b0, cpu_we = 1'b0;
  logic [0:0]  cpu_bank = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready, cpu_rvalid, vid_rvalid;
  logic [7:0]  cpu_rdata, vid_rdata;
  logic        vid_req = 1'b0, vid_phase = 1'b0;
  logic [14:0] vid_waddr = '0;
  logic [7:0]  dram_addr, dram_wdata;
  logic        dram_ras_n, dram_we_n;
  logic [1:0]  dram_cas_n;
  logic [7:0]  dram_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dram_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .perm_mode(perm_mode),
    .cpu_req(cpu_req), .cpu_refresh(cpu_refresh), .cpu_we(cpu_we),
    .cpu_bank(cpu_bank), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .vid_req(vid_req), .vid_waddr(vid_waddr), .vid_phase(vid_phase),
    .vid_rvalid(vid_rvalid), .vid_rdata(vid_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  // target line per address bit, listed A15 first; 8+k = column line k, k = row line k
  localparam int MAP_SWAP [16] = '{14, 15, 12, 13, 10, 11, 8, 6, 7, 4, 5, 2, 3, 0, 1, 9};
  localparam int MAP_ASC  [16] = '{15, 14, 13, 12, 11, 10, 9, 7, 6, 5, 4, 3, 2, 1, 0, 8};

  function automatic int mkey(logic b, logic [7:0] r, logic [7:0] c);
    return int'({b, r, c});
  endfunction

  function automatic logic [7:0] dflt(int k);
    logic [16:0] kk;
    kk = k[16:0];
    return kk[7:0] ^ kk[15:8] ^ (kk[16] ? 8'hC3 : 8'h5A);
  endfunction

  // simple two-bank DRAM model
  logic [7:0] mem [int];
  logic [7:0] row_q = '0;

  always @(posedge clk) begin
    if (!dram_ras_n && dram_cas_n == 2'b11) row_q = dram_addr;
    if (dram_cas_n != 2'b11 && !dram_we_n)
      mem[mkey(!dram_cas_n[1], row_q, dram_addr)] = dram_wdata;
  end

  always @(negedge clk) begin
    if (dram_cas_n != 2'b11) begin
      int k;
      k = mkey(!dram_cas_n[1], row_q, dram_addr);
      dram_rdata = mem.exists(k) ? mem[k] : dflt(k);
    end
  end

  logic [7:0] sb [int];

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic exp_split(logic mode, logic [15:0] a, output logic [7:0] r, output logic [7:0] c);
    r = '0; c = '0;
    for (int b = 0; b < 16; b++) begin
      int t;
      t = mode ? MAP_ASC[15 - b] : MAP_SWAP[15 - b];
      if (t >= 8) c[t - 8] = a[b];
      else        r[t]     = a[b];
    end
  endtask

  // follows one access from grant to the cycle after completion
  task automatic watch(logic vid, logic mode, logic [7:0] er, logic [7:0] ec,
                       logic bank, logic we, logic [7:0] exp_rd);
    logic prev_ras;
    logic [7:0] prev_addr;
    bit done, cas_seen;
    string mt;
    mt = mode ? "R1" : "R2";
    prev_ras = dram_ras_n; prev_addr = dram_addr;
    done = 0; cas_seen = 0;
    for (int i = 1; i <= 12 && !done; i++) begin
      @(negedge clk);
      if (!dram_ras_n && prev_ras) begin
        chk("R4", "cycles to row strobe", i, 2);
        chk(mt, "row half on bus", dram_addr, er);
        chk("R4", "row held before strobe", prev_addr, er);
      end
      if (dram_cas_n !== 2'b11 && !cas_seen) begin
        cas_seen = 1;
        chk(mt, "column half on bus", dram_addr, ec);
        chk(vid ? "R3" : "R5", "column strobe select", dram_cas_n, vid ? 2'b10 : (bank ? 2'b01 : 2'b10));
        chk("R5", "shared row strobe low", dram_ras_n, 0);
        chk("R9", "write enable level", dram_we_n, !we);
        if (we) chk("R9", "write data", dram_wdata, exp_rd);
      end
      if (vid ? vid_rvalid : (cpu_ready && cpu_req)) begin
        done = 1;
        chk("R8", "strobes high together", {dram_ras_n, dram_cas_n}, 3'b111);
        if (vid) chk("R3", "display read data", vid_rdata, exp_rd);
        else if (!we) begin
          chk("R9", "read valid", cpu_rvalid, 1);
          chk("R9", "read data", cpu_rdata, exp_rd);
        end else chk("R9", "no valid on write", cpu_rvalid, 0);
        if (vid) vid_req = 1'b0; else cpu_req = 1'b0;
      end else if (cpu_req && !cpu_refresh) begin
        chk("R7", "processor held waiting", cpu_ready, 0);
      end
      prev_ras = dram_ras_n; prev_addr = dram_addr;
    end
    if (!done) chk("R4", "access completed", 0, 1);
    @(negedge clk);
    chk("R9", "valid is one pulse", {cpu_rvalid, vid_rvalid}, 2'b00);
    chk("R8", "precharge gap", dram_ras_n, 1);
  endtask

  task automatic drive(logic vid, logic mode, logic [15:0] a, logic bank, logic we, logic [7:0] wd);
    perm_mode = mode;
    if (vid) begin
      vid_req = 1'b1; vid_waddr = a[15:1]; vid_phase = a[0];
    end else begin
      cpu_req = 1'b1; cpu_addr = a; cpu_bank = bank; cpu_we = we; cpu_wdata = wd;
    end
  endtask

  function automatic logic [7:0] expect_rd(logic bank, logic [7:0] r, logic [7:0] c);
    int k;
    k = mkey(bank, r, c);
    return sb.exists(k) ? sb[k] : dflt(k);
  endfunction

  // {mode, vid, we, bank, addr, wdata}
  localparam int NV = 14;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 8'hA5},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'h1234, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 8'h00},
    {1'b0, 1'b0, 1'b1, 1'b1, 16'hC001, 8'h3C},
    {1'b0, 1'b0, 1'b0, 1'b1, 16'hC001, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'hC001, 8'h00},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'hC000, 8'h00},
    {1'b0, 1'b1, 1'b0, 1'b0, 16'hC001, 8'h00},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h8003, 8'h00},
    {1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF, 8'h5A},
    {1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 8'h00},
    {1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00},
    {1'b0, 1'b0, 1'b1, 1'b0, 16'hAAAA, 8'h11},
    {1'b1, 1'b1, 1'b0, 1'b0, 16'h5555, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, c, e, r2, c2, e2;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "row strobe in reset", dram_ras_n, 1);
    chk("R10", "column strobes in reset", dram_cas_n, 2'b11);
    chk("R10", "write enable in reset", dram_we_n, 1);
    chk("R10", "valids in reset", {cpu_rvalid, vid_rvalid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic md, vd, w, bk;
      logic [15:0] a;
      logic [7:0] wd;
      {md, vd, w, bk, a, wd} = VEC[v];
      exp_split(md, a, r, c);
      if (vd) bk = 1'b0;
      e = w ? wd : expect_rd(bk, r, c);
      if (w) sb[mkey(bk, r, c)] = wd;
      drive(vd, md, a, bk, w, wd);
      watch(vd, md, r, c, bk, w, e);
    end

    // R6: refresh-phase request is dropped
    cpu_refresh = 1'b1;
    drive(1'b0, 1'b1, 16'h4321, 1'b0, 1'b0, 8'h00);
    #1;
    chk("R6", "ready for refresh cycle", cpu_ready, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6", "no strobe for refresh cycle", {dram_ras_n, dram_cas_n}, 3'b111);
    end
    cpu_req = 1'b0; cpu_refresh = 1'b0;
    @(negedge clk);

    // R7: simultaneous requests, display first
    exp_split(1'b0, 16'h3579, r, c);
    exp_split(1'b0, 16'h2468, r2, c2);
    e = expect_rd(1'b0, r, c);
    e2 = expect_rd(1'b1, r2, c2);
    drive(1'b1, 1'b0, 16'h3579, 1'b0, 1'b0, 8'h00);
    drive(1'b0, 1'b0, 16'h2468, 1'b1, 1'b0, 8'h00);
    #1;
    chk("R7", "processor waits on contest", cpu_ready, 0);
    watch(1'b1, 1'b0, r, c, 1'b0, 1'b0, e);
    watch(1'b0, 1'b0, r2, c2, 1'b1, 1'b0, e2);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule